// File: doc/BRIEF.md
# Pseudo-Random Memory Read-Back Tester

This block stresses an external memory through a plain request port. One run has a write pass followed by a read pass. The write pass stores pseudo-random data at pseudo-random addresses. The read pass replays the same sequence and checks every returned value.

Addresses come from a linear congruential generator over a power-of-two range. It has full period, so each location of the chosen transfer size is hit once before any location repeats, and no stored value is overwritten before it is checked. Data values come from a second, separate generator. Both generators take new seeds from a free-running counter when each run is accepted, so successive runs differ. The read pass reloads those seeds.

Between accesses the block stays idle for a short gap, and the length of each gap is taken from the low bits of that access's data. Requests therefore start at every phase of a 16-cycle arbitration window rather than always on the same cycle. A mismatch raises a sticky fail flag and increments an error counter. The address, expected value and actual value of the first mismatch are held for inspection.

Top module: `prand_mem_checker`

## Requirements
- R1: In each pass, the request addresses visit every size-aligned unit of the 2^AW-byte range exactly once. The order comes from an LCG modulo 2^(AW-shift), where shift is 0, 1 or 2 for 8-, 16- or 32-bit transfers. Every address has its low shift bits at zero.
- R2: Write data comes from a separate xorshift generator that is never zero. Its seed, like the address seed, is derived from a free-running counter sampled when a run is accepted, so two runs produce different data.
- R3: The read pass issues the same addresses, in the same order, as the write pass. It compares each response with the regenerated data for that address.
- R4: The size code is 0 for 8 bits, 1 for 16 bits, and 2 or 3 for 32 bits. Data sits in bits [7:0], [15:0] or [31:0]. Write data bits above the transfer size are zero, and returned bits above it are ignored by the compare.
- R5: After a write handshake, or after a read response that is not the last one, the request line stays low for exactly 1 + D[3:0] cycles. D is the data value of that access. Request starts cover all 16 phases modulo 16.
- R6: The request port uses valid/ready. While valid is high and ready is low, address, write enable and write data are held stable. Only one read is outstanding at a time, and it completes when a response is marked valid.
- R7: Each mismatch increments err_count, which saturates. fail is sticky. first_addr, first_exp and first_act capture only the first mismatch, as masked values. All of these clear when a new run is accepted.
- R8: done pulses for one cycle after the last read is compared. busy is high from run acceptance through that done cycle. start is ignored while busy is high.
- R9: After reset the block is idle: no request is made, busy, done and fail are low, and err_count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run when idle |
| xfer_size | input | 2 | Transfer size code for the run |
| req_valid | output | 1 | Request present |
| req_ready | input | 1 | Memory accepts request |
| req_we | output | 1 | 1 = write, 0 = read |
| req_size | output | 2 | Size code of the request |
| req_addr | output | AW | Byte address |
| req_wdata | output | 32 | Right-justified write data |
| rsp_valid | input | 1 | Read data present |
| rsp_rdata | input | 32 | Right-justified read data |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| fail | output | 1 | Sticky mismatch flag |
| err_count | output | AW+1 | Mismatch count |
| first_addr | output | AW | Address of first mismatch |
| first_exp | output | 32 | Expected value at first mismatch |
| first_act | output | 32 | Returned value at first mismatch |

## Verification
The assertions assume that the memory returns exactly one response for each read it accepts, and that it never raises rsp_valid while no read is waiting. The bench memory follows this rule: it answers one cycle after each read handshake and stays silent otherwise. It also lowers ready on a fixed cycle pattern, so the hold rule is exercised. Corruption is injected only as a constant XOR on every returned word. This keeps the first mismatch on the first read address and makes the error count equal to the number of units whenever the XOR touches an active lane.

// File: rtl/mtst_pkg.sv
package mtst_pkg;

    localparam int DATA_W = 32;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WREQ,
        ST_RREQ,
        ST_RWAIT,
        ST_GAP,
        ST_FIN
    } tst_state_t;

    // size code to byte-address shift: 0 -> 0, 1 -> 1, 2/3 -> 2
    function automatic logic [1:0] sz_shift(input logic [1:0] code);
        case (code)
            2'd0:    sz_shift = 2'd0;
            2'd1:    sz_shift = 2'd1;
            default: sz_shift = 2'd2;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] lane_mask(input logic [1:0] sh);
        case (sh)
            2'd0:    lane_mask = 32'h0000_00FF;
            2'd1:    lane_mask = 32'h0000_FFFF;
            default: lane_mask = 32'hFFFF_FFFF;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] xs_next(input logic [DATA_W-1:0] v);
        logic [DATA_W-1:0] t;
        t = v ^ (v << 13);
        t = t ^ (t >> 17);
        t = t ^ (t << 5);
        return t;
    endfunction

endpackage

// File: rtl/mtst_addr_gen.sv
module mtst_addr_gen #(
    parameter int AW      = 8,
    parameter int LCG_MUL = 69069,
    parameter int LCG_INC = 12345
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          step,
    input  logic [AW-1:0] seed,
    input  logic [1:0]    shift,
    output logic [AW-1:0] addr
);
    // multiplier must be 1 mod 4 and increment odd for full period
    localparam logic [AW-1:0] MUL_T = AW'(LCG_MUL);
    localparam logic [AW-1:0] INC_T = AW'(LCG_INC);

    logic [AW-1:0] x_q;
    logic [AW-1:0] unit_mask;

    always_ff @(posedge clk) begin
        if (rst)       x_q <= '0;
        else if (load) x_q <= seed;
        else if (step) x_q <= x_q * MUL_T + INC_T;
    end

    // low bits of a 2^AW LCG form a full-period LCG of their own
    assign unit_mask = {AW{1'b1}} >> shift;
    assign addr      = (x_q & unit_mask) << shift;

    AST_ADDR_MOVES: assert property (@(posedge clk) disable iff (rst)
        (step && !load) |=> (x_q != $past(x_q))); // R1

endmodule

// File: rtl/mtst_data_gen.sv
module mtst_data_gen
    import mtst_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              step,
    input  logic [DATA_W-1:0] seed,
    output logic [DATA_W-1:0] value
);
    logic [DATA_W-1:0] s_q;

    always_ff @(posedge clk) begin
        if (rst)       s_q <= 32'd1;
        else if (load) s_q <= (seed == '0) ? 32'd1 : seed;
        else if (step) s_q <= xs_next(s_q);
    end

    assign value = s_q;

    AST_DATA_NONZERO: assert property (@(posedge clk) disable iff (rst)
        s_q != '0); // R2

endmodule

// File: rtl/mtst_compare.sv
module mtst_compare
    import mtst_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              check,
    input  logic [AW-1:0]     addr,
    input  logic [DATA_W-1:0] exp_val,
    input  logic [DATA_W-1:0] act_val,
    input  logic [DATA_W-1:0] lmask,
    output logic              fail,
    output logic [AW:0]       errs,
    output logic [AW-1:0]     first_addr,
    output logic [DATA_W-1:0] first_exp,
    output logic [DATA_W-1:0] first_act
);
    logic mismatch;
    assign mismatch = ((exp_val ^ act_val) & lmask) != '0;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            fail       <= 1'b0;
            errs       <= '0;
            first_addr <= '0;
            first_exp  <= '0;
            first_act  <= '0;
        end else if (check && mismatch) begin
            if (errs != {(AW+1){1'b1}}) errs <= errs + 1'b1;
            if (!fail) begin
                fail       <= 1'b1;
                first_addr <= addr;
                first_exp  <= exp_val & lmask;
                first_act  <= act_val & lmask;
            end
        end
    end

    AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (rst)
        (fail && !clear) |=> fail); // R7
    AST_ERR_FLAG: assert property (@(posedge clk) disable iff (rst)
        (errs != '0) |-> fail); // R7

endmodule

// File: rtl/prand_mem_checker.sv
module prand_mem_checker
    import mtst_pkg::*;
#(
    parameter int          AW        = 8,
    parameter int          GAP_BITS  = 4,
    parameter int          LCG_MUL   = 69069,
    parameter int          LCG_INC   = 12345,
    parameter logic [31:0] DATA_SALT = 32'h9E37_79B9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [1:0]    xfer_size,
    output logic          req_valid,
    input  logic          req_ready,
    output logic          req_we,
    output logic [1:0]    req_size,
    output logic [AW-1:0] req_addr,
    output logic [31:0]   req_wdata,
    input  logic          rsp_valid,
    input  logic [31:0]   rsp_rdata,
    output logic          busy,
    output logic          done,
    output logic          fail,
    output logic [AW:0]   err_count,
    output logic [AW-1:0] first_addr,
    output logic [31:0]   first_exp,
    output logic [31:0]   first_act
);
    tst_state_t            state;
    logic [1:0]            sz_q;
    logic [1:0]            shift;
    logic [DATA_W-1:0]     lmask;
    logic [AW-1:0]         units_m1;
    logic [AW-1:0]         cnt;
    logic [GAP_BITS-1:0]   gap;
    logic                  rd_pass;
    logic [31:0]           free_ctr;
    logic [AW-1:0]         a_seed_q, a_seed_in;
    logic [DATA_W-1:0]     d_seed_q, d_seed_in;
    logic [DATA_W-1:0]     dval;
    logic                  accept, wr_hs, rd_done, last, gen_load, gen_step;

    assign shift     = sz_shift(sz_q);
    assign lmask     = lane_mask(shift);
    assign units_m1  = {AW{1'b1}} >> shift;
    assign last      = (cnt == '0);
    assign accept    = (state == ST_IDLE) && start;
    assign wr_hs     = (state == ST_WREQ) && req_ready;
    assign rd_done   = (state == ST_RWAIT) && rsp_valid;
    assign gen_load  = accept || (wr_hs && last);
    assign gen_step  = (wr_hs && !last) || rd_done;
    assign a_seed_in = (state == ST_IDLE) ? free_ctr[AW-1:0] : a_seed_q;
    assign d_seed_in = (state == ST_IDLE) ? (free_ctr ^ DATA_SALT) : d_seed_q;

    always_ff @(posedge clk) begin
        if (rst) free_ctr <= '0;
        else     free_ctr <= free_ctr + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            sz_q     <= '0;
            a_seed_q <= '0;
            d_seed_q <= '0;
            cnt      <= '0;
            gap      <= '0;
            rd_pass  <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    sz_q     <= xfer_size;
                    a_seed_q <= a_seed_in;
                    d_seed_q <= d_seed_in;
                    cnt      <= {AW{1'b1}} >> sz_shift(xfer_size);
                    rd_pass  <= 1'b0;
                    state    <= ST_WREQ;
                end
                ST_WREQ: if (req_ready) begin
                    gap   <= dval[GAP_BITS-1:0];
                    state <= ST_GAP;
                    if (last) begin
                        cnt     <= units_m1;
                        rd_pass <= 1'b1;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_GAP: begin
                    if (gap == '0) state <= rd_pass ? ST_RREQ : ST_WREQ;
                    else           gap   <= gap - 1'b1;
                end
                ST_RREQ:  if (req_ready) state <= ST_RWAIT;
                ST_RWAIT: if (rsp_valid) begin
                    gap <= dval[GAP_BITS-1:0];
                    if (last) begin
                        state <= ST_FIN;
                    end else begin
                        cnt   <= cnt - 1'b1;
                        state <= ST_GAP;
                    end
                end
                ST_FIN:  state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    mtst_addr_gen #(.AW(AW), .LCG_MUL(LCG_MUL), .LCG_INC(LCG_INC)) u_agen (
        .clk(clk), .rst(rst), .load(gen_load), .step(gen_step),
        .seed(a_seed_in), .shift(shift), .addr(req_addr)
    );

    mtst_data_gen u_dgen (
        .clk(clk), .rst(rst), .load(gen_load), .step(gen_step),
        .seed(d_seed_in), .value(dval)
    );

    mtst_compare #(.AW(AW)) u_cmp (
        .clk(clk), .rst(rst), .clear(accept), .check(rd_done),
        .addr(req_addr), .exp_val(dval), .act_val(rsp_rdata), .lmask(lmask),
        .fail(fail), .errs(err_count), .first_addr(first_addr),
        .first_exp(first_exp), .first_act(first_act)
    );

    assign req_valid = (state == ST_WREQ) || (state == ST_RREQ);
    assign req_we    = (state == ST_WREQ);
    assign req_size  = sz_q;
    assign req_wdata = dval & lmask;
    assign busy      = (state != ST_IDLE);
    assign done      = (state == ST_FIN);

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_addr)
            && $stable(req_we) && $stable(req_wdata))); // R6
    AST_GAP_AFTER_HS: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_valid); // R5
    AST_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> ((req_addr & AW'((1 << sz_shift(req_size)) - 1)) == '0)); // R1
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R8

endmodule

// File: tb/tb_prand_mem_checker.sv
module tb_prand_mem_checker;
    localparam int AW = 8;
    localparam int NB = 1 << AW;

    // {size code, xor mask applied to every read response}
    localparam logic [33:0] VEC [6] = '{
        {2'd0, 32'h0000_0000},
        {2'd1, 32'h0000_0000},
        {2'd2, 32'h0000_0000},
        {2'd3, 32'h0001_0000},
        {2'd0, 32'h0000_0100},
        {2'd1, 32'h0000_0080}
    };

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst, start, req_valid, req_ready, req_we, rsp_valid;
    logic          busy, done, fail;
    logic [1:0]    xfer_size, req_size;
    logic [AW-1:0] req_addr, first_addr;
    logic [31:0]   req_wdata, rsp_rdata, first_exp, first_act;
    logic [AW:0]   err_count;

    prand_mem_checker #(.AW(AW)) dut (
        .clk(clk), .rst(rst), .start(start), .xfer_size(xfer_size),
        .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
        .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .busy(busy), .done(done),
        .fail(fail), .err_count(err_count), .first_addr(first_addr),
        .first_exp(first_exp), .first_act(first_act)
    );

    int n_chk = 0, n_bad = 0, cyc = 0;
    bit finished = 0;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // memory model and recorders
    logic [7:0]    mem [NB];
    logic [31:0]   xor_mask = '0, pend_data;
    logic          pending = 1'b0, prev_valid = 1'b0, gap_track = 1'b0;
    logic [15:0]   phase_seen;
    logic [AW-1:0] wr_list [NB];
    logic          seen [NB];
    logic [AW-1:0] first_rd;
    logic [31:0]   first_wd;
    int wr_n, rd_n, rd_bad, dup_cnt, misalign, gap_bad, low_cnt, gap_exp, cur_sh;

    always @(negedge clk) begin
        if (rst) begin
            rsp_valid = 1'b0; pending = 1'b0; req_ready = 1'b0; prev_valid = 1'b0;
            rsp_rdata = '0; gap_track = 1'b0;
        end else begin
            rsp_valid = pending;
            rsp_rdata = pend_data;
            pending   = 1'b0;
            if (req_valid && !prev_valid) begin
                phase_seen[cyc % 16] = 1'b1;
                if (gap_track && low_cnt != gap_exp) gap_bad++;
                gap_track = 1'b0;
            end
            if (!req_valid) low_cnt++;
            prev_valid = req_valid;
            req_ready  = (cyc % 5) != 3;
            if (req_valid && req_ready) begin
                if (req_we) begin
                    for (int b = 0; b < (1 << cur_sh); b++)
                        mem[int'(req_addr) + b] = req_wdata[8*b +: 8];
                    if (seen[int'(req_addr) >> cur_sh]) dup_cnt++;
                    seen[int'(req_addr) >> cur_sh] = 1'b1;
                    if ((int'(req_addr) & ((1 << cur_sh) - 1)) != 0) misalign++;
                    if (wr_n == 0) first_wd = req_wdata;
                    if (wr_n < NB) wr_list[wr_n] = req_addr;
                    wr_n++;
                    gap_track = 1'b1; gap_exp = 1 + int'(req_wdata[3:0]); low_cnt = 0;
                end else begin
                    pend_data = '0;
                    for (int b = 0; b < (1 << cur_sh); b++)
                        pend_data[8*b +: 8] = mem[int'(req_addr) + b];
                    pend_data = pend_data ^ xor_mask;
                    pending = 1'b1;
                    if (rd_n == 0) first_rd = req_addr;
                    if (rd_n >= NB || req_addr != wr_list[rd_n]) rd_bad++;
                    rd_n++;
                end
            end
        end
    end

    logic [31:0] long_first [2];

    task automatic run_vec(input int idx, input logic [1:0] sz, input logic [31:0] msk);
        int sh, units, covered, exp_err;
        logic [31:0] lm, em, mval;
        sh    = (sz == 2'd0) ? 0 : (sz == 2'd1) ? 1 : 2;
        units = NB >> sh;
        lm    = (sh == 0) ? 32'hFF : (sh == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
        em    = msk & lm;
        exp_err = (em != 0) ? units : 0;
        for (int i = 0; i < NB; i++) seen[i] = 1'b0;
        wr_n = 0; rd_n = 0; rd_bad = 0; dup_cnt = 0; misalign = 0; gap_bad = 0;
        phase_seen = '0; xor_mask = msk; cur_sh = sh;
        @(negedge clk); start = 1'b1; xfer_size = sz;
        @(negedge clk); start = 1'b0;
        chk(busy == 1'b1, "R8 busy after start", busy, 1);
        repeat (40) @(negedge clk);
        // start while busy with another size must be ignored
        start = 1'b1; xfer_size = sz ^ 2'd1;
        @(negedge clk); start = 1'b0;
        while (!done) @(negedge clk);
        covered = 0;
        for (int i = 0; i < units; i++) if (seen[i]) covered++;
        chk(wr_n == units && covered == units && dup_cnt == 0, "R1 coverage", covered, units);
        chk(misalign == 0, "R1 alignment", misalign, 0);
        chk(rd_n == units && rd_bad == 0, "R3 replay order", rd_bad, 0);
        chk(gap_bad == 0, "R5 idle gap length", gap_bad, 0);
        chk((first_wd & ~lm) == 0, "R4 upper write bits zero", first_wd, first_wd & lm);
        if (sh == 0) chk(phase_seen == 16'hFFFF, "R5 start phases", phase_seen, 16'hFFFF);
        chk(int'(err_count) == exp_err, "R7 error count", err_count, exp_err);
        chk(fail == (exp_err != 0), "R7 fail flag", fail, exp_err != 0);
        chk(busy == 1'b1, "R8 busy in done cycle", busy, 1);
        if (exp_err != 0) begin
            mval = '0;
            for (int b = 0; b < (1 << sh); b++) mval[8*b +: 8] = mem[int'(first_rd) + b];
            chk(first_addr == first_rd, "R7 first address", first_addr, first_rd);
            chk(first_exp == (mval & lm), "R7 first expected", first_exp, mval & lm);
            chk(first_act == ((mval ^ em) & lm), "R7 first actual", first_act, (mval ^ em) & lm);
        end
        if (idx == 2) long_first[0] = first_wd;
        if (idx == 3) long_first[1] = first_wd;
        @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0, "R8 done single cycle", {done, busy}, 0);
    endtask

    initial begin
        rst = 1'b1; start = 1'b0; xfer_size = '0;
        repeat (3) @(negedge clk);
        chk(req_valid == 1'b0 && busy == 1'b0, "R9 reset idle", {req_valid, busy}, 0);
        chk(fail == 1'b0 && err_count == '0 && done == 1'b0, "R9 reset status", err_count, 0);
        rst = 1'b0;
        repeat (7) @(negedge clk);
        chk(req_valid == 1'b0 && busy == 1'b0, "R9 stays idle", req_valid, 0);
        for (int v = 0; v < 6; v++) run_vec(v, VEC[v][33:32], VEC[v][31:0]);
        chk(long_first[0] != long_first[1], "R2 seed changes per run", long_first[1], ~long_first[0]);
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule